// File: doc/BRIEF.md
# Four-Level Address Translation Walker

This block turns a 48-bit virtual address into a 52-bit physical address. It walks a four-level radix tree of translation tables held in memory. A requester supplies the virtual address, the physical base of the top-level table and the kind of access: a data read, a data write or an instruction fetch. It also states whether the access comes from user or supervisor mode. The walker then fetches one 64-bit table entry per level through a plain read port. That port has a request strobe, an address, a response strobe and response data.

Each table has 512 entries. Each level's 9-bit index comes from a fixed slice of the virtual address. The walk normally ends at the fourth read with a 4 KB page. It ends after the third read when that entry is flagged as a 2 MB page. Write, user and no-execute permissions are gathered along the whole path and checked against the access. The walker returns either the physical address or a fault, and the fault carries a 5-bit cause code.

Only one translation runs at a time. The result stays on the outputs after a one-cycle completion pulse, until the next request is taken.

Top module: `vwalk_top`

## Requirements
- R1: The read address for a level is the table base plus the level's 9-bit index times 8. The walk starts at the supplied root, with its low 12 bits ignored. The indices come from virtual address bits 47:39, 38:30, 29:21 and 20:12, in walk order, and each later base is bits 51:12 of the previous entry followed by 12 zero bits.
- R2: Levels are visited strictly from top to bottom. Each level takes exactly one read. `mem_rd_req` is high for one cycle per read, and the next read is issued only after `mem_rsp_valid` has returned the previous entry.
- R3: An entry with bit 0 clear ends the walk at once with a fault whose code has bit 0 clear.
- R4: A last-level entry that passes all checks gives a physical address made of entry bits 51:12 followed by virtual address bits 11:0.
- R5: A third-read entry with bit 7 set ends the walk after three reads. If it passes all checks, the physical address is entry bits 51:21 followed by virtual address bits 20:0.
- R6: Bit 7 set in the first or second entry read ends the walk with a fault whose code has bit 0 set.
- R7: A write faults (code bit 0 set) unless bit 1 is set in every entry on the path. Every fault raised by a write has code bit 1 set, and reads ignore bit 1.
- R8: A user-mode access faults (code bit 0 set) unless bit 2 is set in every entry on the path. Every fault in user mode has code bit 2 set, and supervisor accesses ignore bit 2.
- R9: A fetch faults (code bit 0 set) if bit 63 is set in any entry on the path. Every fault raised by a fetch has code bit 4 set. Reads ignore bit 63. Code bit 3 is always 0. Access kinds are encoded 0 = read, 1 = write, 2 = fetch, and 3 is taken as a read.
- R10: `req_ready` is high only while no walk is in progress. A `req_valid` seen while busy is dropped and does not affect the walk in progress.
- R11: `done` is a one-cycle pulse. `fault`, `fault_code` and `pa` keep their values after the pulse until another request is taken. `pa` is 0 when a fault is reported.
- R12: After reset, `req_ready` is 1 and both `done` and `mem_rd_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Walker idle, a request will be taken |
| req_vaddr | input | 48 | Virtual address to translate |
| req_root | input | 52 | Physical base of the top-level table |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| req_user | input | 1 | 1 for a user-mode access |
| mem_rd_req | output | 1 | Table entry read strobe |
| mem_rd_addr | output | 52 | Table entry byte address |
| mem_rsp_valid | input | 1 | Entry data returned |
| mem_rsp_data | input | 64 | Table entry contents |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Translation failed |
| fault_code | output | 5 | Fault cause: bit0 protection, bit1 write, bit2 user, bit4 fetch |
| pa | output | 52 | Translated physical address |

## Verification
Complete 4 KB walks use index sets and memory latencies that differ from each other. The logged read addresses then show whether each level takes its own address slice and chains the previous entry's base. Large-page walks check the early stop and the 21-bit offset merge. Faults are placed on different levels, so the read count shows where the walk stopped. Each permission case is run twice, once with the access that must fault and once with an access that must pass. This separates a rule that is gathered along the path from one applied to the wrong access kind. The fault codes check whether a missing entry and a protection failure are told apart. A request made while a walk is busy must leave that walk's result intact.

// File: rtl/vwalk_pkg.sv
package vwalk_pkg;
  localparam int ENT_W  = 64;
  localparam int BIT_V  = 0;
  localparam int BIT_WR = 1;
  localparam int BIT_US = 2;
  localparam int BIT_PS = 7;
  localparam int BIT_NX = 63;

  localparam int EC_W   = 5;
  localparam int EC_P   = 0;
  localparam int EC_WR  = 1;
  localparam int EC_US  = 2;
  localparam int EC_IF  = 4;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } walk_st_e;
endpackage

// File: rtl/vwalk_rst_sync.sv
module vwalk_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/vwalk_index_sel.sv
module vwalk_index_sel #(
  parameter int VA_W   = 48,
  parameter int PA_W   = 52,
  parameter int IDX_W  = 9,
  parameter int OFF_W  = 12,
  parameter int LEVELS = 4
) (
  input  logic [VA_W-1:0]            vaddr,
  input  logic [$clog2(LEVELS)-1:0]  lvl,
  input  logic [PA_W-1:0]            base,
  output logic [PA_W-1:0]            entry_addr
);
  localparam int LVL_W  = $clog2(LEVELS);
  localparam int ESZ_LG = 3;

  logic [IDX_W-1:0] idx_arr [LEVELS];
  logic [IDX_W-1:0] idx_sel;

  for (genvar g = 0; g < LEVELS; g++) begin : g_idx
    assign idx_arr[g] = vaddr[OFF_W + g*IDX_W +: IDX_W];
  end

  always_comb begin
    idx_sel = '0;
    for (int i = 0; i < LEVELS; i++) begin
      if (lvl == LVL_W'(i)) idx_sel = idx_arr[i];
    end
  end

  assign entry_addr = {base[PA_W-1:OFF_W], {OFF_W{1'b0}}}
                    + {{(PA_W-IDX_W-ESZ_LG){1'b0}}, idx_sel, {ESZ_LG{1'b0}}};
endmodule

// File: rtl/vwalk_perm.sv
module vwalk_perm
  import vwalk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             upd,
  input  logic [ENT_W-1:0] ent,
  input  acc_kind_e        kind,
  input  logic             user,
  output logic             fail
);
  logic wr_acc_q, us_acc_q, nx_acc_q;
  logic wr_acc_d, us_acc_d, nx_acc_d;
  logic wr_eff, us_eff, nx_eff;
  logic acc_en;

  assign wr_eff = wr_acc_q & ent[BIT_WR];
  assign us_eff = us_acc_q & ent[BIT_US];
  assign nx_eff = nx_acc_q | ent[BIT_NX];

  assign fail = ((kind == ACC_WRITE) && !wr_eff)
              || (user && !us_eff)
              || ((kind == ACC_FETCH) && nx_eff);

  assign acc_en = start | upd;

  always_comb begin
    wr_acc_d = wr_acc_q;
    us_acc_d = us_acc_q;
    nx_acc_d = nx_acc_q;
    if (start) begin
      wr_acc_d = 1'b1;
      us_acc_d = 1'b1;
      nx_acc_d = 1'b0;
    end else if (upd) begin
      wr_acc_d = wr_eff;
      us_acc_d = us_eff;
      nx_acc_d = nx_eff;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_acc_q <= 1'b1;
      us_acc_q <= 1'b1;
      nx_acc_q <= 1'b0;
    end else if (acc_en) begin
      wr_acc_q <= wr_acc_d;
      us_acc_q <= us_acc_d;
      nx_acc_q <= nx_acc_d;
    end
  end

  // a denied write stays denied for the rest of the walk
  assert_wr_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_acc_q && !start) |=> !wr_acc_q);
  // a denied user access stays denied for the rest of the walk
  assert_us_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!us_acc_q && !start) |=> !us_acc_q);
  // a no-execute mark stays in force for the rest of the walk
  assert_nx_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (nx_acc_q && !start) |=> nx_acc_q);
endmodule

// File: rtl/vwalk_ctrl.sv
module vwalk_ctrl
  import vwalk_pkg::*;
#(
  parameter int VA_W   = 48,
  parameter int PA_W   = 52,
  parameter int IDX_W  = 9,
  parameter int OFF_W  = 12,
  parameter int LEVELS = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic [VA_W-1:0]            req_vaddr,
  input  logic [PA_W-1:0]            req_root,
  input  logic [1:0]                 req_kind,
  input  logic                       req_user,
  input  logic                       rsp_valid,
  input  logic [ENT_W-1:0]           rsp_data,
  input  logic                       perm_fail,
  output logic                       req_ready,
  output logic                       rd_req,
  output logic [VA_W-1:0]            vaddr_q,
  output logic [PA_W-1:0]            base_q,
  output logic [$clog2(LEVELS)-1:0]  lvl_q,
  output acc_kind_e                  kind_q,
  output logic                       user_q,
  output logic                       perm_start,
  output logic                       perm_upd,
  output logic                       done,
  output logic                       fault,
  output logic [EC_W-1:0]            fault_code,
  output logic [PA_W-1:0]            pa
);
  localparam int LVL_W  = $clog2(LEVELS);
  localparam int LG_W   = OFF_W + IDX_W;
  localparam int LG_LVL = 1;

  walk_st_e              st_q, st_d;
  logic [LVL_W-1:0]      lvl_d;
  logic [PA_W-1:0]       base_d;
  logic [VA_W-1:0]       vaddr_d;
  acc_kind_e             kind_d;
  logic                  user_d;
  logic                  done_q, done_d;
  logic                  fault_q, fault_d;
  logic [EC_W-1:0]       code_q, code_d;
  logic [PA_W-1:0]       pa_q, pa_d;
  logic                  accept, finish, walk_en;
  logic                  ent_v, ent_ps, is_leaf, bad_ps;
  logic [EC_W-1:0]       acc_bits;

  assign accept     = (st_q == ST_IDLE) && req_valid;
  assign req_ready  = (st_q == ST_IDLE);
  assign rd_req     = (st_q == ST_ISSUE);
  assign perm_start = accept;
  assign perm_upd   = (st_q == ST_WAIT) && rsp_valid;

  assign ent_v   = rsp_data[BIT_V];
  assign ent_ps  = rsp_data[BIT_PS];
  assign bad_ps  = ent_ps && (lvl_q > LVL_W'(LG_LVL));
  assign is_leaf = (lvl_q == '0) || ((lvl_q == LVL_W'(LG_LVL)) && ent_ps);
  assign finish  = perm_upd && (!ent_v || bad_ps || is_leaf);
  assign walk_en = accept || perm_upd;

  always_comb begin
    acc_bits         = '0;
    acc_bits[EC_WR]  = (kind_q == ACC_WRITE);
    acc_bits[EC_US]  = user_q;
    acc_bits[EC_IF]  = (kind_q == ACC_FETCH);
  end

  always_comb begin
    st_d    = st_q;
    lvl_d   = lvl_q;
    base_d  = base_q;
    vaddr_d = vaddr_q;
    kind_d  = kind_q;
    user_d  = user_q;
    fault_d = fault_q;
    code_d  = code_q;
    pa_d    = pa_q;
    done_d  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          vaddr_d = req_vaddr;
          base_d  = {req_root[PA_W-1:OFF_W], {OFF_W{1'b0}}};
          lvl_d   = LVL_W'(LEVELS-1);
          kind_d  = (req_kind == 2'd1) ? ACC_WRITE :
                    (req_kind == 2'd2) ? ACC_FETCH : ACC_READ;
          user_d  = req_user;
          st_d    = ST_ISSUE;
        end
      end
      ST_ISSUE: st_d = ST_WAIT;
      ST_WAIT: begin
        if (rsp_valid) begin
          if (finish) begin
            st_d    = ST_IDLE;
            done_d  = 1'b1;
            fault_d = 1'b1;
            pa_d    = '0;
            code_d  = acc_bits;
            if (!ent_v) begin
              code_d[EC_P] = 1'b0;
            end else if (bad_ps || perm_fail) begin
              code_d[EC_P] = 1'b1;
            end else begin
              fault_d = 1'b0;
              code_d  = '0;
              if (lvl_q == '0)
                pa_d = {rsp_data[PA_W-1:OFF_W], vaddr_q[OFF_W-1:0]};
              else
                pa_d = {rsp_data[PA_W-1:LG_W], vaddr_q[LG_W-1:0]};
            end
          end else begin
            base_d = {rsp_data[PA_W-1:OFF_W], {OFF_W{1'b0}}};
            lvl_d  = lvl_q - 1'b1;
            st_d   = ST_ISSUE;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q   <= '0;
      base_q  <= '0;
      vaddr_q <= '0;
      kind_q  <= ACC_READ;
      user_q  <= 1'b0;
    end else if (walk_en) begin
      lvl_q   <= lvl_d;
      base_q  <= base_d;
      vaddr_q <= vaddr_d;
      kind_q  <= kind_d;
      user_q  <= user_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= 1'b0;
      code_q  <= '0;
      pa_q    <= '0;
    end else if (finish) begin
      fault_q <= fault_d;
      code_q  <= code_d;
      pa_q    <= pa_d;
    end
  end

  assign done       = done_q;
  assign fault      = fault_q;
  assign fault_code = code_q;
  assign pa         = pa_q;

  assert_one_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);
  assert_lvl_desc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (perm_upd && !finish) |=> (lvl_q == $past(lvl_q) - 1'b1));
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_busy_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> $stable(vaddr_q));
  assert_offset_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fault) |-> (pa[OFF_W-1:0] == vaddr_q[OFF_W-1:0]));
  assert_fault_no_pa_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault) |-> (pa == '0));
endmodule

// File: rtl/vwalk_top.sv
module vwalk_top
  import vwalk_pkg::*;
#(
  parameter int VA_W   = 48,
  parameter int PA_W   = 52,
  parameter int IDX_W  = 9,
  parameter int OFF_W  = 12,
  parameter int LEVELS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [PA_W-1:0]   req_root,
  input  logic [1:0]        req_kind,
  input  logic              req_user,
  output logic              mem_rd_req,
  output logic [PA_W-1:0]   mem_rd_addr,
  input  logic              mem_rsp_valid,
  input  logic [ENT_W-1:0]  mem_rsp_data,
  output logic              done,
  output logic              fault,
  output logic [EC_W-1:0]   fault_code,
  output logic [PA_W-1:0]   pa
);
  localparam int LVL_W = $clog2(LEVELS);

  logic              rst_n_s;
  logic [VA_W-1:0]   vaddr_q;
  logic [PA_W-1:0]   base_q;
  logic [LVL_W-1:0]  lvl_q;
  acc_kind_e         kind_q;
  logic              user_q;
  logic              perm_start, perm_upd, perm_fail;

  vwalk_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  vwalk_index_sel #(
    .VA_W(VA_W), .PA_W(PA_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .LEVELS(LEVELS)
  ) u_idx (
    .vaddr      (vaddr_q),
    .lvl        (lvl_q),
    .base       (base_q),
    .entry_addr (mem_rd_addr)
  );

  vwalk_perm u_perm (
    .clk   (clk),
    .rst_n (rst_n_s),
    .start (perm_start),
    .upd   (perm_upd),
    .ent   (mem_rsp_data),
    .kind  (kind_q),
    .user  (user_q),
    .fail  (perm_fail)
  );

  vwalk_ctrl #(
    .VA_W(VA_W), .PA_W(PA_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .LEVELS(LEVELS)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .req_valid  (req_valid),
    .req_vaddr  (req_vaddr),
    .req_root   (req_root),
    .req_kind   (req_kind),
    .req_user   (req_user),
    .rsp_valid  (mem_rsp_valid),
    .rsp_data   (mem_rsp_data),
    .perm_fail  (perm_fail),
    .req_ready  (req_ready),
    .rd_req     (mem_rd_req),
    .vaddr_q    (vaddr_q),
    .base_q     (base_q),
    .lvl_q      (lvl_q),
    .kind_q     (kind_q),
    .user_q     (user_q),
    .perm_start (perm_start),
    .perm_upd   (perm_upd),
    .done       (done),
    .fault      (fault),
    .fault_code (fault_code),
    .pa         (pa)
  );

  // the read address always lies on an 8-byte entry boundary
  assert_entry_align_R1: assert property (@(posedge clk) disable iff (!rst_n_s)
    mem_rd_req |-> (mem_rd_addr[2:0] == 3'b000));
endmodule

// File: tb/vwalk_top_bench.sv
`timescale 1ns/1ps
module vwalk_top_bench;
  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [47:0] req_vaddr;
  logic [51:0] req_root;
  logic [1:0]  req_kind;
  logic        req_user;
  logic        mem_rd_req;
  logic [51:0] mem_rd_addr;
  logic        mem_rsp_valid;
  logic [63:0] mem_rsp_data;
  logic        done;
  logic        fault;
  logic [4:0]  fault_code;
  logic [51:0] pa;

  int tests = 0;
  int fails = 0;
  int lat   = 2;

  logic [63:0] mem [logic [51:0]];
  logic [51:0] addr_log [8];
  int          nlog;
  int          rcnt;
  logic [51:0] raddr;

  logic        r_fault;
  logic [4:0]  r_code;
  logic [51:0] r_pa;

  localparam logic [51:0] T4 = 52'h10000;
  localparam logic [51:0] T3 = 52'h20000;
  localparam logic [51:0] T2 = 52'h30000;
  localparam logic [51:0] T1 = 52'h40000;
  localparam logic [51:0] PG4K = 52'hABCDE000;
  localparam logic [51:0] PG2M = 52'h123400000;

  vwalk_top u_vwalk_top (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_root(req_root),
    .req_kind(req_kind), .req_user(req_user),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .done(done), .fault(fault), .fault_code(fault_code), .pa(pa)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // memory responder: one entry per request after lat negedges
  initial begin
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    nlog = 0;
    rcnt = 0;
    raddr = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      mem_rsp_data  = '0;
      if (rcnt > 0) begin
        rcnt--;
        if (rcnt == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = mem.exists(raddr) ? mem[raddr] : 64'h0;
        end
      end else if (mem_rd_req) begin
        raddr = mem_rd_addr;
        if (nlog < 8) addr_log[nlog] = mem_rd_addr;
        nlog++;
        rcnt = lat;
      end
    end
  end

  function automatic logic [63:0] mk(input logic [51:0] base, input logic nx,
                                     input logic ps, input logic u,
                                     input logic w, input logic v);
    return {nx, 11'b0, base[51:12], 4'b0, ps, 4'b0, u, w, v};
  endfunction

  function automatic logic [63:0] ok(input logic [51:0] base);
    return mk(base, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
  endfunction

  function automatic logic [51:0] eaddr(input logic [51:0] base, input logic [8:0] idx);
    return {base[51:12], 12'h0} + {40'h0, idx, 3'b000};
  endfunction

  function automatic logic [4:0] ecode(input logic p, input logic [1:0] kind, input logic user);
    return {kind == 2'd2, 1'b0, user, kind == 2'd1, p};
  endfunction

  function automatic logic [47:0] mkva(input logic [8:0] a, input logic [8:0] b,
                                       input logic [8:0] c, input logic [8:0] d,
                                       input logic [11:0] off);
    return {a, b, c, d, off};
  endfunction

  task automatic build(input logic [47:0] va, input logic [63:0] e4, input logic [63:0] e3,
                       input logic [63:0] e2, input logic [63:0] e1);
    mem.delete();
    mem[eaddr(T4, va[47:39])] = e4;
    mem[eaddr(T3, va[38:30])] = e3;
    mem[eaddr(T2, va[29:21])] = e2;
    mem[eaddr(T1, va[20:12])] = e1;
  endtask

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic run(input logic [47:0] va, input logic [1:0] kind, input logic user);
    while (!req_ready) @(negedge clk);
    nlog = 0;
    req_vaddr = va;
    req_root  = T4 | 52'h5A5;
    req_kind  = kind;
    req_user  = user;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!done) @(negedge clk);
    r_fault = fault;
    r_code  = fault_code;
    r_pa    = pa;
  endtask

  task automatic t_reset();
    chk("R12 req_ready after reset", req_ready, 1);
    chk("R12 done after reset", done, 0);
    chk("R12 mem_rd_req after reset", mem_rd_req, 0);
  endtask

  task automatic t_walk_4k();
    logic [47:0] va;
    va = mkva(9'd5, 9'd17, 9'd300, 9'd511, 12'hABC);
    build(va, ok(T3), ok(T2), ok(T1), ok(PG4K));
    lat = 2;
    run(va, 2'd0, 1'b0);
    chk("R4 4k fault", r_fault, 0);
    chk("R4 4k pa", r_pa, {PG4K[51:12], 12'hABC});
    chk("R2 4k read count", nlog, 4);
    chk("R1 addr level4", addr_log[0], eaddr(T4, 9'd5));
    chk("R1 addr level3", addr_log[1], eaddr(T3, 9'd17));
    chk("R1 addr level2", addr_log[2], eaddr(T2, 9'd300));
    chk("R1 addr level1", addr_log[3], eaddr(T1, 9'd511));
    va = mkva(9'd256, 9'd1, 9'd0, 9'd77, 12'h001);
    build(va, ok(T3), ok(T2), ok(T1), ok(PG4K));
    lat = 1;
    run(va, 2'd1, 1'b1);
    chk("R4 4k pa second pattern", r_pa, {PG4K[51:12], 12'h001});
    chk("R1 addr level2 second pattern", addr_log[2], eaddr(T2, 9'd0));
    chk("R1 addr level1 second pattern", addr_log[3], eaddr(T1, 9'd77));
    lat = 2;
  endtask

  task automatic t_large();
    logic [47:0] va;
    va = mkva(9'd3, 9'd4, 9'd9, 9'h1F3, 12'h7E5);
    build(va, ok(T3), ok(T2), mk(PG2M, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1), 64'h0);
    run(va, 2'd0, 1'b1);
    chk("R5 2M fault", r_fault, 0);
    chk("R5 2M pa", r_pa, {PG2M[51:21], va[20:0]});
    chk("R5 2M read count", nlog, 3);
  endtask

  task automatic t_absent();
    logic [47:0] va;
    va = mkva(9'd8, 9'd9, 9'd10, 9'd11, 12'h0);
    build(va, ok(T3), mk(T2, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0), ok(T1), ok(PG4K));
    run(va, 2'd1, 1'b1);
    chk("R3 absent level3 fault", r_fault, 1);
    chk("R3 absent level3 code", r_code, ecode(1'b0, 2'd1, 1'b1));
    chk("R3 absent level3 read count", nlog, 2);
    chk("R11 pa zero on fault", r_pa, 0);
    build(va, ok(T3), ok(T2), ok(T1), 64'h0);
    run(va, 2'd0, 1'b0);
    chk("R3 absent leaf code", r_code, ecode(1'b0, 2'd0, 1'b0));
    chk("R3 absent leaf fault", r_fault, 1);
  endtask

  task automatic t_bad_large();
    logic [47:0] va;
    va = mkva(9'd1, 9'd2, 9'd3, 9'd4, 12'h0);
    build(va, mk(T3, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1), ok(T2), ok(T1), ok(PG4K));
    run(va, 2'd0, 1'b0);
    chk("R6 ps at level4 code", r_code, ecode(1'b1, 2'd0, 1'b0));
    chk("R6 ps at level4 reads", nlog, 1);
    build(va, ok(T3), mk(T2, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1), ok(T1), ok(PG4K));
    run(va, 2'd2, 1'b0);
    chk("R6 ps at level3 code", r_code, ecode(1'b1, 2'd2, 1'b0));
    chk("R6 ps at level3 reads", nlog, 2);
  endtask

  task automatic t_write();
    logic [47:0] va;
    va = mkva(9'd20, 9'd21, 9'd22, 9'd23, 12'h444);
    build(va, ok(T3), mk(T2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1), ok(T1), ok(PG4K));
    run(va, 2'd1, 1'b0);
    chk("R7 write to read-only path", r_code, ecode(1'b1, 2'd1, 1'b0));
    chk("R7 write fault flag", r_fault, 1);
    run(va, 2'd0, 1'b0);
    chk("R7 read of read-only path", r_fault, 0);
    chk("R7 read pa", r_pa, {PG4K[51:12], 12'h444});
  endtask

  task automatic t_user();
    logic [47:0] va;
    va = mkva(9'd30, 9'd31, 9'd32, 9'd33, 12'h010);
    build(va, ok(T3), ok(T2), ok(T1), mk(PG4K, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1));
    run(va, 2'd0, 1'b1);
    chk("R8 user read of supervisor page", r_code, ecode(1'b1, 2'd0, 1'b1));
    run(va, 2'd0, 1'b0);
    chk("R8 supervisor read allowed", r_fault, 0);
  endtask

  task automatic t_nx();
    logic [47:0] va;
    va = mkva(9'd40, 9'd41, 9'd42, 9'd43, 12'h888);
    build(va, ok(T3), ok(T2), mk(T1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1), ok(PG4K));
    run(va, 2'd2, 1'b0);
    chk("R9 fetch from no-execute path", r_code, ecode(1'b1, 2'd2, 1'b0));
    run(va, 2'd2, 1'b1);
    chk("R9 user fetch code", r_code, ecode(1'b1, 2'd2, 1'b1));
    run(va, 2'd0, 1'b0);
    chk("R9 read ignores no-execute", r_fault, 0);
    run(va, 2'd3, 1'b0);
    chk("R9 kind 3 acts as read", r_fault, 0);
  endtask

  task automatic t_busy();
    logic [47:0] va, vb;
    va = mkva(9'd50, 9'd51, 9'd52, 9'd53, 12'h123);
    vb = mkva(9'd60, 9'd61, 9'd62, 9'd63, 12'hFED);
    build(va, ok(T3), ok(T2), ok(T1), ok(PG4K));
    while (!req_ready) @(negedge clk);
    nlog = 0;
    req_vaddr = va; req_root = T4; req_kind = 2'd0; req_user = 1'b0;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk("R10 ready low while busy", req_ready, 0);
    req_vaddr = vb; req_kind = 2'd1; req_user = 1'b1;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!done) @(negedge clk);
    chk("R10 busy request ignored pa", pa, {PG4K[51:12], 12'h123});
    chk("R10 busy request ignored fault", fault, 0);
    chk("R10 reads of first walk only", nlog, 4);
  endtask

  task automatic t_hold();
    logic [47:0] va;
    va = mkva(9'd70, 9'd71, 9'd72, 9'd73, 12'h5A5);
    build(va, ok(T3), ok(T2), ok(T1), ok(PG4K));
    run(va, 2'd0, 1'b0);
    @(negedge clk);
    chk("R11 done drops after one cycle", done, 0);
    repeat (3) @(negedge clk);
    chk("R11 pa held", pa, r_pa);
    chk("R11 fault held", fault, r_fault);
    chk("R11 ready back after walk", req_ready, 1);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_vaddr = '0;
    req_root  = '0;
    req_kind  = 2'd0;
    req_user  = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_walk_4k();
    t_large();
    t_absent();
    t_bad_large();
    t_write();
    t_user();
    t_nx();
    t_busy();
    t_hold();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule